// File: doc/BRIEF.md
# Continuous Memory CRC Scrubber

The block walks a memory of `DEPTH` 32-bit words over a synchronous read port, one address per enabled tick, and folds every word into a 32-bit CRC. At the end of each walk it XORs the result with an expected value held in a storage register and keeps the outcome in a signature register. A zero signature means the memory matched. Any nonzero value raises `crc_err`, which stays up through the whole next walk. That walk alone decides whether the flag clears. Walks repeat without end once the user-mode input has been seen high, and only reset stops them.

The expected value is loaded in one cycle by a configuration-done strobe. It can also be rewritten one bit at a time through a serial scan path, but only while a 10-bit instruction input holds the selecting code. This path lets test software inject a wrong expectation and see the flag respond. The scan in progress keeps running throughout. A programmable divider sets the pace: the whole engine advances once every F base clocks, and F is taken from its input at the first tick of each walk.

Top module: `memscan_crc_checker`

## Requirements
- R1: After reset `signature` is 0, `crc_err` is 0, `mem_rd` is 0 and `scan_tdo` is 0.
- R2: No memory read is issued before `user_mode` is seen high. After that, scanning starts with no other input and continues until reset.
- R3: Each walk reads addresses 0 to DEPTH-1 in ascending order, one read per tick, and wraps to 0 for the next walk. `pass_end` is high for one cycle on the tick after the last word is absorbed, and walks repeat indefinitely.
- R4: The CRC is computed MSB first with polynomial 0x04C11DB7 and an all-ones seed, with no reflection and no final inversion. It absorbs one 32-bit word per tick, starting with address 0. Read data is taken from `mem_rdata` at the tick after the read was issued.
- R5: In the cycle after `pass_end`, `signature` becomes the final CRC XOR the storage register value at that tick. A stored value equal to the memory's CRC gives 0.
- R6: `crc_err` is high exactly when `signature` is nonzero. It changes only in the cycle after `pass_end`, so it holds through the following walk, and a clean walk clears it whatever earlier walks found.
- R7: A `cfg_done` pulse loads `cfg_expect` into the storage register in one cycle. The load takes priority over a shift in the same cycle.
- R8: While `ir_code` equals 10'b00_0001_0101 and `scan_shift` is high, the storage register shifts toward bit 0 once per clock, with `scan_tdi` entering bit 31. `scan_tdo` shows bit 0 before the shift.
- R9: With any other `ir_code`, `scan_shift` has no effect on the storage register, and `scan_tdo` is 0.
- R10: Shifting the storage register does not stall, restart or lengthen the running walk.
- R11: A tick occurs once every F base clocks, where F is `div_factor` and 0 counts as 1. F is sampled at the first tick of each walk. The spacing between `pass_end` pulses is therefore F_prev + (DEPTH+1)*F_new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | End-of-configuration strobe, loads the expected value |
| cfg_expect | input | 32 | Precomputed expected CRC |
| user_mode | input | 1 | User-mode entry; starts checking when high |
| div_factor | input | DIVW | Tick division factor (0 acts as 1) |
| mem_rd | output | 1 | Synchronous read strobe |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 32 | Read data, valid from the cycle after a read |
| ir_code | input | IRW | Instruction code selecting the scan path |
| scan_shift | input | 1 | Shift enable for the scan path |
| scan_tdi | input | 1 | Serial data in |
| scan_tdo | output | 1 | Serial data out |
| signature | output | 32 | Last walk's CRC XOR expected value |
| crc_err | output | 1 | Mismatch flag of the last completed walk |
| pass_end | output | 1 | Tick that closes a walk |

## Verification
The bench corrupts one memory word and then restores it. A design whose flag is sticky across walks would keep `crc_err` high after the clean walk, and one that reacts mid-walk would drop it early. It injects a new expectation serially while a slow walk runs. Wrong shift direction shows up in the signature, a scan path that pauses the engine shows up in the `pass_end` spacing, and a wrong `scan_tdo` tap shows up in the bits shifted out. It also changes the division factor, including to 0, between walks to catch a divider that samples at the wrong moment. Finally it shifts with a non-selecting code and strobes a load together with a shift, to catch a missing decode and an inverted priority.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // Fold one word into the running CRC, data MSB first.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] cur,
                                                 input logic [CRC_W-1:0] word);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = cur;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ word[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  // Mismatch pattern: zero when the computed and expected values agree.
  function automatic logic [CRC_W-1:0] mismatch(input logic [CRC_W-1:0] got,
                                                 input logic [CRC_W-1:0] want);
    return got ^ want;
  endfunction
endpackage

// File: rtl/crcchk_tick_div.sv
module crcchk_tick_div #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            reload,
  input  logic [DIVW-1:0] div_in,
  output logic            tick,
  output logic [DIVW-1:0] factor
);
  localparam logic [DIVW-1:0] ONE = DIVW'(1);

  function automatic logic [DIVW-1:0] eff(input logic [DIVW-1:0] f);
    return (f == '0) ? ONE : f;
  endfunction

  logic [DIVW-1:0] fac_q, cnt_q;

  assign tick   = run && (cnt_q == fac_q - ONE);
  assign factor = fac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fac_q <= ONE;
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      fac_q <= eff(div_in);
    end else if (tick) begin
      cnt_q <= '0;
      if (reload) fac_q <= eff(div_in);
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/crcchk_scan_seq.sv
module crcchk_scan_seq
  import crcchk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CRC_W-1:0] rdata,
  output logic             rd,
  output logic [AW-1:0]    addr,
  output logic             at_start,
  output logic             fin_tick,
  output logic [CRC_W-1:0] crc
);
  localparam int          IW     = $clog2(DEPTH + 2);
  localparam logic [IW-1:0] DEP_I  = IW'(DEPTH);
  localparam logic [IW-1:0] LAST_I = IW'(DEPTH + 1);

  logic [IW-1:0]    idx_q;
  logic [CRC_W-1:0] crc_q;
  logic             absorb, finish;

  assign at_start = (idx_q == '0);
  assign absorb   = !at_start && (idx_q <= DEP_I);
  assign finish   = (idx_q == LAST_I);
  assign rd       = tick && (idx_q < DEP_I);
  assign addr     = rd ? idx_q[AW-1:0] : '0;
  assign fin_tick = tick && finish;
  assign crc      = crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      crc_q <= CRC_SEED;
    end else if (tick) begin
      if (at_start)    crc_q <= CRC_SEED;
      else if (absorb) crc_q <= crc_fold(crc_q, rdata);
      idx_q <= finish ? '0 : idx_q + IW'(1);
    end
  end
endmodule

// File: rtl/crcchk_expect_reg.sv
module crcchk_expect_reg #(
  parameter int             W         = 32,
  parameter int             IRW       = 10,
  parameter logic [IRW-1:0] SEL_CODE  = 10'b00_0001_0101,
  parameter bit             LSB_FIRST = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   load_val,
  input  logic [IRW-1:0] ir,
  input  logic           shift_en,
  input  logic           tdi,
  output logic           tdo,
  output logic           sel,
  output logic [W-1:0]   val
);
  logic [W-1:0] q, shifted;
  logic         out_bit;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign shifted = {tdi, q[W-1:1]};
      assign out_bit = q[0];
    end else begin : g_msb
      assign shifted = {q[W-2:0], tdi};
      assign out_bit = q[W-1];
    end
  endgenerate

  assign sel = (ir == SEL_CODE);
  assign tdo = sel ? out_bit : 1'b0;
  assign val = q;

  always_ff @(posedge clk) begin
    if (!rst_n)                q <= '0;
    else if (load)             q <= load_val;
    else if (sel && shift_en)  q <= shifted;
  end
endmodule

// File: rtl/memscan_crc_checker.sv
module memscan_crc_checker
  import crcchk_pkg::*;
#(
  parameter int             DEPTH      = 16,
  parameter int             DIVW       = 8,
  parameter int             IRW        = 10,
  parameter logic [IRW-1:0] EDREG_CODE = 10'b00_0001_0101,
  parameter bit             SHIFT_LSB  = 1'b1,
  localparam int            AW         = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic [CRC_W-1:0] cfg_expect,
  input  logic             user_mode,
  input  logic [DIVW-1:0]  div_factor,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic [CRC_W-1:0] mem_rdata,
  input  logic [IRW-1:0]   ir_code,
  input  logic             scan_shift,
  input  logic             scan_tdi,
  output logic             scan_tdo,
  output logic [CRC_W-1:0] signature,
  output logic             crc_err,
  output logic             pass_end
);
  // Named internal events, also watched by the bound checker.
  logic             run_q;
  logic             tick_en;
  logic             seq_at_start;
  logic             pass_begin;
  logic             pass_fin;
  logic             shift_sel;
  logic [DIVW-1:0]  cur_factor;
  logic [CRC_W-1:0] crc_now;
  logic [CRC_W-1:0] store_val;
  logic [CRC_W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_q <= 1'b0;
    else if (user_mode) run_q <= 1'b1;
  end

  crcchk_tick_div #(.DIVW(DIVW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .reload (seq_at_start),
    .div_in (div_factor),
    .tick   (tick_en),
    .factor (cur_factor)
  );

  crcchk_scan_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .rdata    (mem_rdata),
    .rd       (mem_rd),
    .addr     (mem_addr),
    .at_start (seq_at_start),
    .fin_tick (pass_fin),
    .crc      (crc_now)
  );

  crcchk_expect_reg #(
    .W(CRC_W), .IRW(IRW), .SEL_CODE(EDREG_CODE), .LSB_FIRST(SHIFT_LSB)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_done),
    .load_val (cfg_expect),
    .ir       (ir_code),
    .shift_en (scan_shift),
    .tdi      (scan_tdi),
    .tdo      (scan_tdo),
    .sel      (shift_sel),
    .val      (store_val)
  );

  assign pass_begin = tick_en && seq_at_start;

  always_ff @(posedge clk) begin
    if (!rst_n)        sig_q <= '0;
    else if (pass_fin) sig_q <= mismatch(crc_now, store_val);
  end

  assign signature = sig_q;
  assign crc_err   = |sig_q;
  assign pass_end  = pass_fin;
endmodule

// File: rtl/memscan_crc_checker_chk.sv
module memscan_crc_checker_chk #(
  parameter int DIVW      = 8,
  parameter bit SHIFT_LSB = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_q,
  input logic            tick_en,
  input logic            pass_begin,
  input logic            pass_end,
  input logic            mem_rd,
  input logic            cfg_done,
  input logic [31:0]     cfg_expect,
  input logic            shift_sel,
  input logic            scan_shift,
  input logic            scan_tdi,
  input logic [31:0]     store_val,
  input logic [31:0]     signature,
  input logic            crc_err,
  input logic [DIVW-1:0] cur_factor
);
  // R2
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !mem_rd);
  // R2
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);
  // R3
  read_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> tick_en);
  // R5
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_end |=> $stable(signature));
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_end |=> $stable(crc_err));
  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> store_val == $past(cfg_expect));
  // R8
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_sel && scan_shift && !cfg_done) |=>
      ((SHIFT_LSB ? store_val[31] : store_val[0]) == $past(scan_tdi)));
  // R9
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_done && !(shift_sel && scan_shift)) |=> $stable(store_val));
  // R11
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !pass_begin && cur_factor > DIVW'(1)) |=> !tick_en);
endmodule

bind memscan_crc_checker memscan_crc_checker_chk #(.DIVW(DIVW), .SHIFT_LSB(SHIFT_LSB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_q      (run_q),
  .tick_en    (tick_en),
  .pass_begin (pass_begin),
  .pass_end   (pass_end),
  .mem_rd     (mem_rd),
  .cfg_done   (cfg_done),
  .cfg_expect (cfg_expect),
  .shift_sel  (shift_sel),
  .scan_shift (scan_shift),
  .scan_tdi   (scan_tdi),
  .store_val  (store_val),
  .signature  (signature),
  .crc_err    (crc_err),
  .cur_factor (cur_factor)
);

// File: tb/memscan_crc_checker_test.sv
`timescale 1ns/1ps
module memscan_crc_checker_test;
  localparam int DEPTH = 16;
  localparam int DIVW  = 8;
  localparam int IRW   = 10;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [IRW-1:0] SEL = 10'b00_0001_0101;

  logic            clk = 1'b0;
  logic            rst_n, cfg_done, user_mode, scan_shift, scan_tdi;
  logic [31:0]     cfg_expect, mem_rdata, signature;
  logic [DIVW-1:0] div_factor;
  logic [IRW-1:0]  ir_code;
  logic            mem_rd, scan_tdo, crc_err, pass_end;
  logic [AW-1:0]   mem_addr;
  logic [31:0]     mem [DEPTH];

  always #10 clk = ~clk;

  memscan_crc_checker #(.DEPTH(DEPTH), .DIVW(DIVW), .IRW(IRW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .cfg_expect(cfg_expect),
    .user_mode(user_mode), .div_factor(div_factor), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ir_code(ir_code),
    .scan_shift(scan_shift), .scan_tdi(scan_tdi), .scan_tdo(scan_tdo),
    .signature(signature), .crc_err(crc_err), .pass_end(pass_end)
  );

  // Synchronous-read memory model
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Reference CRC: XOR the word into the top, then 32 polynomial steps.
  function automatic logic [31:0] ref_crc();
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int w = 0; w < DEPTH; w++) begin
      c = c ^ mem[w];
      for (int b = 0; b < 32; b++)
        c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    return c;
  endfunction

  function automatic int eff(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  typedef struct { logic [31:0] sig; int period; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic push(input logic [31:0] s, input int p, input string t);
    exp_t e;
    e.sig = s; e.period = p; e.tag = t;
    sb_q.push_back(e);
  endtask

  // Monitor: addresses, and signature/flag/period after every pass_end
  int  cycn = 0, last_end = 0, seen_period = 0, exp_addr = 0;
  bit  end_seen = 0;
  always @(negedge clk) begin
    cycn++;
    if (end_seen) begin
      exp_t e;
      end_seen = 0;
      if (sb_q.size() == 0) chk(0, "R3 unexpected pass", 0, 1);
      else begin
        e = sb_q.pop_front();
        chk(signature == e.sig, {e.tag, " R5 signature"}, signature, e.sig);
        chk(crc_err == (e.sig != 0), {e.tag, " R6 flag"}, 32'(crc_err), 32'(e.sig != 0));
        if (e.period > 0)
          chk(seen_period == e.period, {e.tag, " R11 period"}, seen_period, e.period);
      end
    end
    if (rst_n && mem_rd) begin
      chk(int'(mem_addr) == exp_addr, "R3 address", 32'(mem_addr), exp_addr);
      exp_addr = (exp_addr + 1) % DEPTH;
    end
    if (rst_n && pass_end) begin
      end_seen    = 1;
      seen_period = cycn - last_end;
      last_end    = cycn;
    end
  end

  task automatic wait_end();
    do @(negedge clk); while (!pass_end);
  endtask

  task automatic shift32(input logic [IRW-1:0] code, input logic [31:0] val,
                         output logic [31:0] outbits);
    ir_code = code;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      outbits[i] = scan_tdo;
      scan_tdi   = val[i];
      scan_shift = 1'b1;
      @(negedge clk);
    end
    scan_shift = 1'b0;
    ir_code    = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] good, bad, inj, outb;
    int rd_cnt;
    rst_n = 0; cfg_done = 0; user_mode = 0; scan_shift = 0; scan_tdi = 0;
    cfg_expect = 0; div_factor = 2; ir_code = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F96;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(signature == 0, "R1 signature", signature, 0);
    chk(crc_err == 0, "R1 flag", 32'(crc_err), 0);
    chk(scan_tdo == 0, "R1 tdo", 32'(scan_tdo), 0);
    rd_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (mem_rd) rd_cnt++;
      @(negedge clk);
    end
    chk(rd_cnt == 0, "R2 idle reads", rd_cnt, 0);

    good = ref_crc();
    cfg_expect = good; cfg_done = 1;
    @(negedge clk);
    cfg_done = 0;
    push(0, 0, "R4 first");
    user_mode = 1;
    @(negedge clk);
    user_mode = 0;
    rd_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      if (mem_rd) rd_cnt++;
      @(negedge clk);
    end
    chk(rd_cnt > 0, "R2 autostart", rd_cnt, 1);

    wait_end();                       // pass 1 done
    div_factor = 3;
    push(0, 2 + (DEPTH + 1) * 3, "R11 f3");
    wait_end();                       // pass 2 done
    mem[5] = mem[5] ^ 32'h0001_0000;
    bad = ref_crc();
    div_factor = 0;
    push(bad ^ good, 3 + (DEPTH + 1) * 1, "R4 corrupt");
    wait_end();                       // pass 3 done: error
    mem[5] = mem[5] ^ 32'h0001_0000;
    push(0, 1 + (DEPTH + 1) * 1, "R6 clean");
    repeat (4) @(negedge clk);
    chk(crc_err == 1, "R6 held", 32'(crc_err), 1);
    wait_end();                       // pass 4 done: clean
    div_factor = 4;
    repeat (2) @(negedge clk);
    chk(crc_err == 0, "R6 cleared", 32'(crc_err), 0);
    inj = 32'h5EED_1234;
    shift32(SEL, inj, outb);
    chk(outb == good, "R8 tdo", outb, good);
    push(good ^ inj, 1 + (DEPTH + 1) * 4, "R10 inject");
    wait_end();                       // pass 5 done: injected error
    shift32(10'h016, 32'h1234_5678, outb);
    chk(outb == 0, "R9 tdo", outb, 0);
    push(good ^ inj, 4 + (DEPTH + 1) * 4, "R9 ignore");
    wait_end();                       // pass 6 done
    ir_code = SEL; scan_shift = 1; scan_tdi = 1; cfg_expect = good; cfg_done = 1;
    @(negedge clk);
    cfg_done = 0; scan_shift = 0; ir_code = 0;
    push(0, 4 + (DEPTH + 1) * 4, "R7 priority");
    wait_end();                       // pass 7 done
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R3 all passes seen", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule